// File: doc/BRIEF.md
# Extension Enable Control Register

This block holds the machine-level register that tells the rest of a hart which letter-named instruction-set extensions are switched on. Each of the 26 letters A to Z owns one bit, at its position in the alphabet. The two most significant bits report the native register width and are read-only. Privileged software writes the register at run time. The block accepts each write only in bits that are both implemented and writable. It refuses writes that would leave a dependent extension on while its prerequisite is off. It keeps the base-integer and embedded options mutually exclusive.

The current enables leave the block as one output bit per letter. Decode logic describes the instruction it is looking at with a request vector, one bit per extension that the instruction needs. The block answers with a per-extension fault vector and a single illegal-instruction flag. A request for hypervisor instructions or CSRs while the H bit is clear therefore traps, just as it would if the extension did not exist.

The block also holds the machine and supervisor exception-PC registers. Their bit 1 is tied to the compressed extension. The stored bit always keeps the last value written. While compressed instructions are disabled, reads and the fetch view show that bit as 0. State that belongs to other extensions, such as floating-point or vector registers, is not kept here. After an extension is re-enabled, the contents of that state are undefined.

Top module: `ext_enable_csr`

## Requirements
- R1: After reset the extension field holds every implemented extension enabled, except that E is clear when I is also implemented. With the default parameters the field is 0x1411AD, and a read of the register (csr_sel 0) returns 0x401411AD: width code 01 in bits 31:30, zeros in bits 29:26.
- R2: A write with csr_sel 0 and csr_we high takes effect on the next clock edge. It changes only the bits in the writable-and-implemented mask: C, D, F, H, I and S by default. The fixed bits A, M and U keep their value whatever is written.
- R3: When both I (bit 8) and E (bit 4) are implemented, E always reads as the inverse of I, and a value written to bit 4 has no effect.
- R4: If a write would leave D (bit 3) set with F (bit 5) clear, or Q (bit 16) set with D clear, then F, D and Q keep their previous values. The other bits of the same write still take effect. Clearing D while F stays set is accepted.
- R5: If a write would leave H (bit 7) set with S (bit 18) clear, then H and S keep their previous values.
- R6: ext_en equals bits 25:0 of the register at all times.
- R7: When acc_valid is high, acc_fault is acc_req with every enabled extension removed, and illegal_insn is high when any bit of acc_fault is set. When acc_valid is low, both outputs are zero. A request for H (bit 7) while H is disabled faults.
- R8: The exception-PC registers (csr_sel 1 for machine, 2 for supervisor) store every written bit, bit 1 included, even while C is disabled. Bit 0 always reads 0.
- R9: While C (bit 2) is disabled, bit 1 reads as 0 on csr_rdata, mepc_fetch and sepc_fetch. Re-enabling C shows the stored bit 1 again, unchanged.
- R10: csr_sel 3 reads 0, and a write with csr_sel 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_sel | input | 2 | Register select: 0 extension register, 1 machine exception PC, 2 supervisor exception PC, 3 none |
| csr_we | input | 1 | Write strobe for the selected register |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data of the selected register (combinational) |
| ext_en | output | 26 | Per-letter extension enables |
| acc_valid | input | 1 | Decode presents a request this cycle |
| acc_req | input | 26 | Extensions needed by the current instruction or CSR access |
| acc_fault | output | 26 | Requested extensions that are disabled |
| illegal_insn | output | 1 | Any requested extension is disabled |
| mepc_fetch | output | XLEN | Machine exception PC as seen by fetch |
| sepc_fetch | output | XLEN | Supervisor exception PC as seen by fetch |

## Verification
Some properties are checked on every cycle. The fixed letters never move. D never stands without F, and H never stands without S. I and E are exactly one-hot. A disabled H always traps a hypervisor request. An exception PC changes only on a write, and its visible bit 1 is zero while C is off. The bench scenarios cover what no single-cycle property can show: the reset value, rejected writes that leave the whole floating-point group as it was, and the hidden bit 1 reappearing after C is switched off, written and switched back on.

// File: rtl/ext_ctl_pkg.sv
// Package: shared constants and types for the extension enable register.
// Assumes letter-ordered bit positions (bit 0 = A ... bit 25 = Z).
package ext_ctl_pkg;
    localparam int EXT_N  = 26;
    localparam int BIT_C  = 2;
    localparam int BIT_D  = 3;
    localparam int BIT_E  = 4;
    localparam int BIT_F  = 5;
    localparam int BIT_H  = 7;
    localparam int BIT_I  = 8;
    localparam int BIT_Q  = 16;
    localparam int BIT_S  = 18;

    typedef enum logic [1:0] {
        SEL_ISA  = 2'd0,
        SEL_MEPC = 2'd1,
        SEL_SEPC = 2'd2,
        SEL_NONE = 2'd3
    } csr_sel_e;

    // Width code reported in the two top bits of the register
    function automatic logic [1:0] width_code(input int xlen);
        if (xlen == 32)      return 2'b01;
        else if (xlen == 64) return 2'b10;
        else                 return 2'b11;
    endfunction
endpackage

// File: rtl/ext_write_filter.sv
// Module: ext_write_filter
// Computes the next extension field from the current one and a write value.
// Only writable, implemented bits move. E follows ~I when both exist.
// Writes that break a dependency (D needs F, Q needs D, H needs S) leave
// the affected group at its current value. Purely combinational.
module ext_write_filter
    import ext_ctl_pkg::*;
#(
    parameter logic [EXT_N-1:0] IMPL_MASK = '1,
    parameter logic [EXT_N-1:0] WR_MASK   = '0
) (
    input  logic [EXT_N-1:0] cur,
    input  logic [EXT_N-1:0] wdata,
    output logic [EXT_N-1:0] nxt
);
    localparam logic [EXT_N-1:0] ONE      = {{(EXT_N-1){1'b0}}, 1'b1};
    localparam bit               HAS_I    = IMPL_MASK[BIT_I];
    localparam bit               HAS_E    = IMPL_MASK[BIT_E];
    localparam bit               BOTH_IE  = HAS_I && HAS_E;
    localparam logic [EXT_N-1:0] I_GATE   = BOTH_IE ? '1 : ~(ONE << BIT_I);
    localparam logic [EXT_N-1:0] WR_EFF   = WR_MASK & IMPL_MASK & ~(ONE << BIT_E) & I_GATE;

    logic [EXT_N-1:0] prop;
    logic             fp_bad;
    logic             hs_bad;

    // Merge the write into writable bits, then veto illegal combinations
    always_comb begin
        prop = (cur & ~WR_EFF) | (wdata & WR_EFF);
        if (BOTH_IE) begin
            prop[BIT_E] = ~prop[BIT_I];
        end
        fp_bad = (prop[BIT_D] & ~prop[BIT_F]) | (prop[BIT_Q] & ~prop[BIT_D]);
        hs_bad = prop[BIT_H] & ~prop[BIT_S];
        nxt    = prop;
        if (fp_bad) begin
            nxt[BIT_F] = cur[BIT_F];
            nxt[BIT_D] = cur[BIT_D];
            nxt[BIT_Q] = cur[BIT_Q];
        end
        if (hs_bad) begin
            nxt[BIT_H] = cur[BIT_H];
            nxt[BIT_S] = cur[BIT_S];
        end
    end
endmodule

// File: rtl/ext_access_check.sv
// Module: ext_access_check
// Compares the extensions a decoded instruction needs against the enables.
// Assumes acc_req is meaningful only while acc_valid is high.
module ext_access_check
    import ext_ctl_pkg::*;
(
    input  logic [EXT_N-1:0] en,
    input  logic             acc_valid,
    input  logic [EXT_N-1:0] acc_req,
    output logic [EXT_N-1:0] acc_fault,
    output logic             illegal_insn
);
    // Fault every requested extension that is switched off
    always_comb begin
        acc_fault    = acc_valid ? (acc_req & ~en) : '0;
        illegal_insn = |acc_fault;
    end
endmodule

// File: rtl/epc_reg.sv
// Module: epc_reg
// One exception-PC register. Stores every written bit. The view clears
// bit 0 always and bit 1 while compressed instructions are disabled.
// Assumes wr_en is already qualified by the register select.
module epc_reg #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wdata,
    input  logic            c_en,
    output logic [XLEN-1:0] view
);
    logic [XLEN-1:0] stored;

    // Capture the full write value, including bit 1 while C is off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored <= '0;
        end else if (wr_en) begin
            stored <= wdata;
        end
    end

    // Present the value with alignment masking applied
    always_comb begin
        view    = stored;
        view[0] = 1'b0;
        view[1] = stored[1] & c_en;
    end

    // R8: the stored value moves only on a write
    p_epc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(stored));

    // R9: bit 1 hidden while C is disabled
    p_epc_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !c_en |-> (view[1] == 1'b0));
endmodule

// File: rtl/ext_enable_csr.sv
// Module: ext_enable_csr (top)
// Writable extension enable register with legal-write filtering, per-letter
// enables, access-fault flags and the two exception-PC registers.
// Assumes XLEN >= 32 and a single CSR access port.
module ext_enable_csr
    import ext_ctl_pkg::*;
#(
    parameter int                XLEN      = 32,
    parameter logic [EXT_N-1:0]  IMPL_MASK = 26'h1411BD,
    parameter logic [EXT_N-1:0]  WR_MASK   = 26'h0401AC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       csr_sel,
    input  logic             csr_we,
    input  logic [XLEN-1:0]  csr_wdata,
    output logic [XLEN-1:0]  csr_rdata,
    output logic [EXT_N-1:0] ext_en,
    input  logic             acc_valid,
    input  logic [EXT_N-1:0] acc_req,
    output logic [EXT_N-1:0] acc_fault,
    output logic             illegal_insn,
    output logic [XLEN-1:0]  mepc_fetch,
    output logic [XLEN-1:0]  sepc_fetch
);
    localparam int               PAD_W   = XLEN - 2 - EXT_N;
    localparam logic [EXT_N-1:0] ONE     = {{(EXT_N-1){1'b0}}, 1'b1};
    localparam bit               BOTH_IE = IMPL_MASK[BIT_I] && IMPL_MASK[BIT_E];
    localparam logic [EXT_N-1:0] RST_EXT = IMPL_MASK & ~(BOTH_IE ? (ONE << BIT_E) : '0);
    localparam logic [EXT_N-1:0] FIXED   = ~(WR_MASK | (ONE << BIT_E) | (ONE << BIT_I));
    localparam int               N_EPC   = 2;

    csr_sel_e         sel;
    logic [EXT_N-1:0] ext_q;
    logic [EXT_N-1:0] ext_nxt;
    logic [XLEN-1:0]  epc_view [N_EPC];

    assign sel    = csr_sel_e'(csr_sel);
    assign ext_en = ext_q;

    ext_write_filter #(
        .IMPL_MASK (IMPL_MASK),
        .WR_MASK   (WR_MASK)
    ) u_filter (
        .cur   (ext_q),
        .wdata (csr_wdata[EXT_N-1:0]),
        .nxt   (ext_nxt)
    );

    // Hold the extension field; load the filtered value on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= RST_EXT;
        end else if (csr_we && sel == SEL_ISA) begin
            ext_q <= ext_nxt;
        end
    end

    ext_access_check u_acc (
        .en           (ext_q),
        .acc_valid    (acc_valid),
        .acc_req      (acc_req),
        .acc_fault    (acc_fault),
        .illegal_insn (illegal_insn)
    );

    // One exception-PC register per privilege level
    for (genvar g = 0; g < N_EPC; g++) begin : g_epc
        localparam csr_sel_e MY_SEL = (g == 0) ? SEL_MEPC : SEL_SEPC;
        epc_reg #(.XLEN(XLEN)) u_epc (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (csr_we && sel == MY_SEL),
            .wdata (csr_wdata),
            .c_en  (ext_q[BIT_C]),
            .view  (epc_view[g])
        );
    end

    assign mepc_fetch = epc_view[0];
    assign sepc_fetch = epc_view[1];

    // Read multiplexer for the selected register
    always_comb begin
        unique case (sel)
            SEL_ISA:  csr_rdata = {width_code(XLEN), {PAD_W{1'b0}}, ext_q};
            SEL_MEPC: csr_rdata = epc_view[0];
            SEL_SEPC: csr_rdata = epc_view[1];
            default:  csr_rdata = '0;
        endcase
    end

    // R2: fixed letters never change
    p_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ext_q & FIXED) == ($past(ext_q) & FIXED)));

    // R4: D is never on without F
    p_fp_dep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_q[BIT_D] |-> ext_q[BIT_F]);

    // R5: H is never on without S
    p_hs_dep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_q[BIT_H] |-> ext_q[BIT_S]);

    // R7: hypervisor requests trap while H is off
    p_hyp_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_req[BIT_H] && !ext_en[BIT_H]) |-> illegal_insn);

    if (BOTH_IE) begin : g_ie_chk
        // R3: exactly one of I and E is selected
        p_ie_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot({ext_q[BIT_I], ext_q[BIT_E]}));
    end
endmodule

// File: tb/tb_ext_enable_csr.sv
`timescale 1ns/100ps
module tb_ext_enable_csr;
    localparam int XLEN = 32;
    localparam int K_RD = 0, K_EN = 1, K_ILL = 2, K_FLT = 3, K_MF = 4, K_SF = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      csr_sel = 2'd0;
    logic            csr_we = 1'b0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_rdata;
    logic [25:0]     ext_en;
    logic            acc_valid = 1'b0;
    logic [25:0]     acc_req = '0;
    logic [25:0]     acc_fault;
    logic            illegal_insn;
    logic [XLEN-1:0] mepc_fetch;
    logic [XLEN-1:0] sepc_fetch;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string       tag;
        int          kind;
        logic [31:0] exp;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    ext_enable_csr dut (
        .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .ext_en(ext_en),
        .acc_valid(acc_valid), .acc_req(acc_req), .acc_fault(acc_fault),
        .illegal_insn(illegal_insn), .mepc_fetch(mepc_fetch), .sepc_fetch(sepc_fetch)
    );

    function automatic logic [31:0] observe(int kind);
        case (kind)
            K_RD:    return csr_rdata;
            K_EN:    return {6'd0, ext_en};
            K_ILL:   return {31'd0, illegal_insn};
            K_FLT:   return {6'd0, acc_fault};
            K_MF:    return mepc_fetch;
            default: return sepc_fetch;
        endcase
    endfunction

    // Monitor: compare queued expectations midway through the low phase
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = observe(it.kind);
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind %0d actual %h expected %h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic push(string tag, int kind, logic [31:0] exp);
        item_t it;
        it.tag = tag; it.kind = kind; it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] data);
        @(negedge clk);
        csr_sel = sel; csr_we = 1'b1; csr_wdata = data;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(string tag, logic [1:0] sel, logic [31:0] exp);
        @(negedge clk);
        csr_sel = sel;
        push(tag, K_RD, exp);
    endtask

    task automatic req(string tag, logic v, logic [25:0] r, logic ill, logic [25:0] flt);
        @(negedge clk);
        acc_valid = v; acc_req = r;
        push(tag, K_ILL, {31'd0, ill});
        push(tag, K_FLT, {6'd0, flt});
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd("R1", 2'd0, 32'h401411AD);
        push("R1_R6", K_EN, 32'h001411AD);
        rd("R1", 2'd1, 32'h0);
        // R2 / R3: clear everything writable; fixed letters stay, E takes over
        wr(2'd0, 32'h0);
        rd("R2_R3", 2'd0, 32'h40101011);
        push("R6", K_EN, 32'h00101011);
        wr(2'd0, 32'hFFFFFFFF);
        rd("R2_R3", 2'd0, 32'h401411AD);
        // R4 floating-point group
        wr(2'd0, 32'h0014118D);
        rd("R4_reject", 2'd0, 32'h401411AD);
        wr(2'd0, 32'h001411A5);
        rd("R4_d_off", 2'd0, 32'h401411A5);
        wr(2'd0, 32'h00141185);
        rd("R4_f_off", 2'd0, 32'h40141185);
        wr(2'd0, 32'h0014118D);
        rd("R4_reject2", 2'd0, 32'h40141185);
        wr(2'd0, 32'hFFFFFFFF);
        // R5 H needs S
        wr(2'd0, 32'h001011AD);
        rd("R5_reject", 2'd0, 32'h401411AD);
        wr(2'd0, 32'h0010112D);
        rd("R5_both_off", 2'd0, 32'h4010112D);
        wr(2'd0, 32'h001011AD);
        rd("R5_reject2", 2'd0, 32'h4010112D);
        wr(2'd0, 32'h0014112D);
        rd("R5_s_on", 2'd0, 32'h4014112D);
        // R7 access faults with H off
        req("R7_hyp", 1'b1, 26'h80, 1'b1, 26'h80);
        req("R7_m", 1'b1, 26'h1000, 1'b0, 26'h0);
        req("R7_mix", 1'b1, 26'hA0, 1'b1, 26'h80);
        req("R7_novalid", 1'b0, 26'h80, 1'b0, 26'h0);
        wr(2'd0, 32'hFFFFFFFF);
        req("R7_h_on", 1'b1, 26'h80, 1'b0, 26'h0);
        req("R7_idle", 1'b0, 26'h0, 1'b0, 26'h0);
        // R8 / R9 exception-PC bit 1
        wr(2'd1, 32'h12345677);
        rd("R8", 2'd1, 32'h12345676);
        wr(2'd0, 32'hFFFFFFFB);
        rd("R9_c_off", 2'd0, 32'h401411A9);
        rd("R9_mask", 2'd1, 32'h12345674);
        push("R9_fetch", K_MF, 32'h12345674);
        wr(2'd1, 32'h00000F0E);
        rd("R9_wr_off", 2'd1, 32'h00000F0C);
        wr(2'd2, 32'hABCD0002);
        rd("R9_s_off", 2'd2, 32'hABCD0000);
        push("R9_sfetch", K_SF, 32'hABCD0000);
        wr(2'd0, 32'hFFFFFFFF);
        rd("R8_restore", 2'd1, 32'h00000F0E);
        push("R8_mfetch", K_MF, 32'h00000F0E);
        rd("R8_srestore", 2'd2, 32'hABCD0002);
        push("R8_sfetch", K_SF, 32'hABCD0002);
        // R10 unused select
        wr(2'd3, 32'h0);
        rd("R10_read", 2'd3, 32'h0);
        rd("R10_isa", 2'd0, 32'h401411AD);
        rd("R10_mepc", 2'd1, 32'h00000F0E);
        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
    end
endmodule